// File: doc/BRIEF.md
# I2C Target Port Expander Controller

This block is an I2C target that lets a bus master set eight open-drain port pins and a small analog control word, and read back a packed byte of comparator results. It runs from a fast system clock. SCL and SDA are oversampled, synchronized and filtered, and all bus events are found in the system clock domain. The target answers at a seven-bit address. The upper four bits of that address are fixed at binary 0111, and the lower three come from strap inputs.

A write carries one or two data bytes after the address. The first byte sets the port drive register. The second byte holds three fields: a capture-mode flag, a threshold-source select and a six-bit DAC code. A read first gives a snapshot of the eight comparator inputs, captured during the address acknowledge. The master may then keep reading bytes, acknowledging each one, until it sends a NACK. Strobes tell the capture logic when a snapshot was taken and when the master acknowledged a byte.

Top module: `pexp_i2c_target`

## Requirements
- R1: The target acknowledges only an address byte whose upper seven bits equal {0111, strap[2], strap[1], strap[0]}, with bit 0 giving the direction (0 write, 1 read). A byte with any other address is not acknowledged and changes no output register.
- R2: The first byte after a write address is acknowledged and loaded into `port_release`, with bit n going to pin n. It takes effect at that byte's ACK. A 1 releases the pin and a 0 pulls it low.
- R3: The second write byte is acknowledged and split into three fields: bit 7 sets `cap_mode`, bit 6 sets `thr_sel`, and bits 5..0 set `dac_code`. These take effect at that byte's ACK.
- R4: A write address followed directly by STOP is acknowledged and leaves every register unchanged.
- R5: A third or later byte in a write is not acknowledged and changes no register.
- R6: A read address loads the transmit shift register from `cmp_in` during its ACK clock and pulses `snap_load` once. The byte is sent MSB first, so `cmp_in[7]` goes out first. Bits 7..5 are comparator-A results for pins 7..5, and bits 4..0 are comparator-B results for pins 4..0.
- R7: A master ACK on a read byte pulses `mack_pulse` and reloads the shift register from `cmp_in` for the next byte. A master NACK ends the read, and the target leaves SDA released until the next START. The target never drives SDA during the master's acknowledge slot.
- R8: After reset, `port_release` is 0x00, `dac_code` is 1, `thr_sel` is 0, `cap_mode` is 0 and SDA is released.
- R9: A START received in the middle of a byte aborts the transfer without changing any register, and address reception begins again.
- R10: The target starts pulling SDA low only while the filtered SCL is low.
- R11: An SCL pulse shorter than the filter length (4 system clocks by default) is ignored and does not count as a bit clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Sensed level of the SCL line |
| sda_in | input | 1 | Sensed level of the SDA line |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| strap | input | 3 | Address strap inputs, low three address bits |
| cmp_in | input | 8 | Comparator results, already synchronous to clk |
| port_release | output | 8 | Port drive register, 1 releases a pin, 0 pulls it low |
| dac_code | output | 6 | DAC input code |
| thr_sel | output | 1 | Threshold source select for comparator B |
| cap_mode | output | 1 | Capture-mode flag for the capture block |
| snap_load | output | 1 | One-cycle pulse when the read snapshot is taken |
| mack_pulse | output | 1 | One-cycle pulse on a master ACK of a read byte |

## Verification
The hardest case to reach from the ports is a START that arrives part-way through a byte, in the address phase or in a data phase, followed straight away by a valid transfer. The bench drives a partial address and then a partial data byte, each cut short by a repeated START. It checks that the port register keeps its old value through both aborts and then takes the value of the transfer that completes. Two further cases need careful timing: a read whose snapshot changes between bytes, and an SCL glitch that lasts only two system clocks. The bench drives both at exact cycle offsets inside a bit period.

// File: rtl/pexp_pkg.sv
// Package pexp_pkg
// Shared constants and the transfer state type for the port expander target.
// Assumes byte-oriented I2C transfers with 7-bit addressing.
package pexp_pkg;
    localparam int BYTE_W   = 8;
    localparam int PORT_W   = 8;
    localparam int DAC_W    = 6;
    localparam int STRAP_W  = 3;
    localparam int FILT_LEN = 4;
    localparam logic [3:0] ADDR_HI = 4'b0111;
    localparam logic [DAC_W-1:0] DAC_RST = DAC_W'(1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK
    } tgt_state_e;
endpackage

// File: rtl/pexp_line_filter.sv
// Module pexp_line_filter
// Two-flop synchronizer followed by a majority-free run filter: the output
// only moves once FILT_LEN consecutive synchronized samples agree.
// Assumes the line idles high (bus released) and FILT_LEN >= 2.
module pexp_line_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    logic [1:0]          sync_q;
    logic [FILT_LEN-1:0] hist_q;
    logic                out_q;

    // Synchronize the raw line and keep a window of recent samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            hist_q <= '1;
        end else begin
            sync_q <= {sync_q[0], line_i};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
        end
    end

    // Move the filtered level only when the whole window agrees.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b1;
        end else if (&hist_q) begin
            out_q <= 1'b1;
        end else if (~|hist_q) begin
            out_q <= 1'b0;
        end
    end

    assign line_o = out_q;
endmodule

// File: rtl/pexp_bus_events.sv
// Module pexp_bus_events
// Turns filtered SCL/SDA levels into one-cycle event pulses: SCL edges,
// START (SDA falls with SCL high) and STOP (SDA rises with SCL high).
// Assumes inputs are already synchronous and glitch-filtered.
module pexp_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_p;
    logic sda_p;

    // Remember the previous filtered levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    // Decode edges and bus conditions from current and previous levels.
    always_comb begin
        scl_rise  = scl_f & ~scl_p;
        scl_fall  = ~scl_f & scl_p;
        start_det = scl_f & scl_p & sda_p & ~sda_f;
        stop_det  = scl_f & scl_p & ~sda_p & sda_f;
    end
endmodule

// File: rtl/pexp_target_fsm.sv
// Module pexp_target_fsm
// Bit and byte engine of the I2C target. Samples SDA on SCL rise, changes its
// own SDA drive only after SCL fall, matches the address, issues write strobes
// for the first two data bytes and shifts out comparator snapshots on reads.
// Assumes cmp_in is synchronous to clk.
module pexp_target_fsm
    import pexp_pkg::*;
#(
    parameter int          STRAP_BITS = STRAP_W,
    parameter logic [3:0]  ADDR_UPPER = ADDR_HI
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_f,
    input  logic                  sda_f,
    input  logic                  scl_rise,
    input  logic                  scl_fall,
    input  logic                  start_det,
    input  logic                  stop_det,
    input  logic [STRAP_BITS-1:0] strap,
    input  logic [BYTE_W-1:0]     cmp_in,
    output logic                  sda_low,
    output logic                  wr_port_en,
    output logic                  wr_ctl_en,
    output logic [BYTE_W-1:0]     wr_data,
    output logic                  snap_load,
    output logic                  mack_pulse
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [1:0] IDX_SAT = 2'd2;

    tgt_state_e        state_q;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [BYTE_W-1:0] rx_sh_q;
    logic [BYTE_W-1:0] tx_sh_q;
    logic              rw_q;
    logic [1:0]        byte_idx_q;
    logic              sda_low_q;
    logic              mack_q;
    logic              full_q;
    logic              wr_port_q;
    logic              wr_ctl_q;
    logic              snap_q;
    logic              mack_p_q;
    logic              addr_hit;

    // Address comparison against the fixed upper nibble and the straps.
    assign addr_hit = (rx_sh_q[BYTE_W-1:1] == {ADDR_UPPER, strap});

    // Transfer sequencing, shift registers and SDA drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            bit_cnt_q  <= '0;
            rx_sh_q    <= '0;
            tx_sh_q    <= '0;
            rw_q       <= 1'b0;
            byte_idx_q <= '0;
            sda_low_q  <= 1'b0;
            mack_q     <= 1'b0;
            full_q     <= 1'b0;
            wr_port_q  <= 1'b0;
            wr_ctl_q   <= 1'b0;
            snap_q     <= 1'b0;
            mack_p_q   <= 1'b0;
        end else begin
            wr_port_q <= 1'b0;
            wr_ctl_q  <= 1'b0;
            snap_q    <= 1'b0;
            mack_p_q  <= 1'b0;
            if (start_det) begin
                state_q   <= ST_ADDR;
                bit_cnt_q <= '0;
                full_q    <= 1'b0;
                sda_low_q <= 1'b0;
            end else if (stop_det) begin
                state_q   <= ST_IDLE;
                full_q    <= 1'b0;
                sda_low_q <= 1'b0;
            end else begin
                case (state_q)
                    ST_ADDR, ST_WDATA: begin
                        if (scl_rise) begin
                            rx_sh_q   <= {rx_sh_q[BYTE_W-2:0], sda_f};
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                            if (bit_cnt_q == LAST_BIT) begin
                                full_q <= 1'b1;
                            end
                        end else if (scl_fall && full_q) begin
                            full_q <= 1'b0;
                            if (state_q == ST_ADDR) begin
                                if (addr_hit) begin
                                    sda_low_q <= 1'b1;
                                    rw_q      <= rx_sh_q[0];
                                    state_q   <= ST_AACK;
                                end else begin
                                    state_q <= ST_IDLE;
                                end
                            end else if (byte_idx_q != IDX_SAT) begin
                                sda_low_q <= 1'b1;
                                wr_port_q <= (byte_idx_q == 2'd0);
                                wr_ctl_q  <= (byte_idx_q == 2'd1);
                                state_q   <= ST_WACK;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (scl_rise && rw_q) begin
                            tx_sh_q <= cmp_in;
                            snap_q  <= 1'b1;
                        end else if (scl_fall) begin
                            bit_cnt_q <= '0;
                            if (rw_q) begin
                                sda_low_q <= ~tx_sh_q[BYTE_W-1];
                                state_q   <= ST_RDATA;
                            end else begin
                                sda_low_q  <= 1'b0;
                                byte_idx_q <= '0;
                                state_q    <= ST_WDATA;
                            end
                        end
                    end
                    ST_WACK: begin
                        if (scl_fall) begin
                            sda_low_q <= 1'b0;
                            bit_cnt_q <= '0;
                            if (byte_idx_q != IDX_SAT) begin
                                byte_idx_q <= byte_idx_q + 1'b1;
                            end
                            state_q <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            if (bit_cnt_q == LAST_BIT) begin
                                sda_low_q <= 1'b0;
                                bit_cnt_q <= '0;
                                state_q   <= ST_RACK;
                            end else begin
                                tx_sh_q   <= {tx_sh_q[BYTE_W-2:0], 1'b0};
                                sda_low_q <= ~tx_sh_q[BYTE_W-2];
                                bit_cnt_q <= bit_cnt_q + 1'b1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            mack_q <= ~sda_f;
                            if (!sda_f) begin
                                tx_sh_q  <= cmp_in;
                                mack_p_q <= 1'b1;
                            end
                        end else if (scl_fall) begin
                            if (mack_q) begin
                                sda_low_q <= ~tx_sh_q[BYTE_W-1];
                                state_q   <= ST_RDATA;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                    default: begin
                        sda_low_q <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign sda_low    = sda_low_q;
    assign wr_port_en = wr_port_q;
    assign wr_ctl_en  = wr_ctl_q;
    assign wr_data    = rx_sh_q;
    assign snap_load  = snap_q;
    assign mack_pulse = mack_p_q;

    // R10
    drive_low_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_low_q) |-> !scl_f);

    // R9
    start_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state_q == ST_ADDR && bit_cnt_q == '0));

    // R7
    rack_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RACK) |-> !sda_low_q);

    // R6
    snap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap_q |=> !snap_q);
endmodule

// File: rtl/pexp_ctrl_regs.sv
// Module pexp_ctrl_regs
// Holds the port drive register and the control register (capture mode,
// threshold select, DAC code). Loads each from the shared write byte when
// its strobe pulses. Assumes strobes are single-cycle and mutually exclusive.
module pexp_ctrl_regs
    import pexp_pkg::*;
#(
    parameter int               P_W   = PORT_W,
    parameter int               D_W   = DAC_W,
    parameter logic [D_W-1:0]   D_RST = DAC_RST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_port_en,
    input  logic              wr_ctl_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [P_W-1:0]    port_q,
    output logic [D_W-1:0]    dac_q,
    output logic              thr_q,
    output logic              cap_q
);
    localparam int CAP_BIT = BYTE_W - 1;
    localparam int THR_BIT = BYTE_W - 2;

    // Port drive register: all pins pulled low after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q <= '0;
        end else if (wr_port_en) begin
            port_q <= wr_data[P_W-1:0];
        end
    end

    // Control register fields decoded from the second write byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_q <= D_RST;
            thr_q <= 1'b0;
            cap_q <= 1'b0;
        end else if (wr_ctl_en) begin
            dac_q <= wr_data[D_W-1:0];
            thr_q <= wr_data[THR_BIT];
            cap_q <= wr_data[CAP_BIT];
        end
    end

    // R2
    port_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(port_q) |-> $past(wr_port_en));

    // R3
    ctl_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(dac_q) || !$stable(thr_q) || !$stable(cap_q)) |-> $past(wr_ctl_en));

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_port_en && wr_ctl_en));
endmodule

// File: rtl/pexp_i2c_target.sv
// Module pexp_i2c_target
// Top of the I2C port expander target: filters both bus lines, extracts bus
// events, runs the transfer engine and holds the output registers.
// Assumes clk is at least 50 times the SCL rate and cmp_in is synchronous.
module pexp_i2c_target
    import pexp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_drive_low,
    input  logic [STRAP_W-1:0] strap,
    input  logic [BYTE_W-1:0]  cmp_in,
    output logic [PORT_W-1:0]  port_release,
    output logic [DAC_W-1:0]   dac_code,
    output logic               thr_sel,
    output logic               cap_mode,
    output logic               snap_load,
    output logic               mack_pulse
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] filt_lines;
    logic scl_f, sda_f;
    logic scl_rise, scl_fall, start_det, stop_det;
    logic wr_port_en, wr_ctl_en;
    logic [BYTE_W-1:0] wr_data;

    assign raw_lines = {sda_in, scl_in};

    // One synchronizer and filter per bus line.
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        pexp_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (filt_lines[g])
        );
    end

    assign scl_f = filt_lines[0];
    assign sda_f = filt_lines[1];

    pexp_bus_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f     (scl_f),
        .sda_f     (sda_f),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    pexp_target_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_f      (scl_f),
        .sda_f      (sda_f),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .strap      (strap),
        .cmp_in     (cmp_in),
        .sda_low    (sda_drive_low),
        .wr_port_en (wr_port_en),
        .wr_ctl_en  (wr_ctl_en),
        .wr_data    (wr_data),
        .snap_load  (snap_load),
        .mack_pulse (mack_pulse)
    );

    pexp_ctrl_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_port_en (wr_port_en),
        .wr_ctl_en  (wr_ctl_en),
        .wr_data    (wr_data),
        .port_q     (port_release),
        .dac_q      (dac_code),
        .thr_q      (thr_sel),
        .cap_q      (cap_mode)
    );

    // R8
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det) |=> !sda_drive_low);
endmodule

// File: tb/pexp_i2c_target_bench.sv
// Bench for pexp_i2c_target: a vector table of write transfers walked by one
// loop, then directed tests for reset, reads, aborts and SCL glitches.
module pexp_i2c_target_bench;
    localparam int Q = 40;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [6:0] MY_ADR = {4'b0111, STRAP};

    typedef struct packed {
        logic [6:0] adr;
        logic [1:0] nb;
        logic [7:0] d0;
        logic [7:0] d1;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{7'h3D, 2'd1, 8'hA5, 8'h00},
        '{7'h3D, 2'd2, 8'h3C, 8'hC7},
        '{7'h35, 2'd2, 8'hFF, 8'h00},
        '{7'h7D, 2'd1, 8'h00, 8'h00},
        '{7'h3D, 2'd0, 8'h00, 8'h00},
        '{7'h3D, 2'd2, 8'h81, 8'h2A}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic [7:0] cmp_in = 8'h00;
    logic sda_drive_low, thr_sel, cap_mode, snap_load, mack_pulse;
    logic [7:0] port_release;
    logic [5:0] dac_code;
    logic sda_line;
    int checks = 0;
    int errors = 0;
    int snap_cnt = 0;
    int mack_cnt = 0;
    logic [7:0] m_port = 8'h00;
    logic [7:0] m_ctl = 8'h01;
    bit done = 0;

    assign sda_line = m_sda & ~sda_drive_low;

    always #2.5 clk = ~clk;

    pexp_i2c_target u_pexp_i2c_target (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (m_scl),
        .sda_in        (sda_line),
        .sda_drive_low (sda_drive_low),
        .strap         (STRAP),
        .cmp_in        (cmp_in),
        .port_release  (port_release),
        .dac_code      (dac_code),
        .thr_sel       (thr_sel),
        .cap_mode      (cap_mode),
        .snap_load     (snap_load),
        .mack_pulse    (mack_pulse)
    );

    always @(posedge clk) begin
        if (snap_load) snap_cnt <= snap_cnt + 1;
        if (mack_pulse) mack_cnt <= mack_cnt + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_q(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_q(Q);
        m_scl = 1'b1; wait_q(Q);
        m_sda = 1'b0; wait_q(Q);
        m_scl = 1'b0; wait_q(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_q(Q);
        m_scl = 1'b1; wait_q(Q);
        m_sda = 1'b1; wait_q(Q);
    endtask

    task automatic clk_bit(input logic b, output logic s, input bit glitch);
        m_sda = b; wait_q(Q);
        if (glitch) begin
            m_scl = 1'b1; wait_q(2);
            m_scl = 1'b0; wait_q(Q);
        end
        m_scl = 1'b1; wait_q(Q);
        s = sda_line; wait_q(Q);
        m_scl = 1'b0; wait_q(Q);
    endtask

    task automatic wr_byte(input logic [7:0] d, output logic ack, input int glitch_bit);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(d[i], s, (i == glitch_bit));
        clk_bit(1'b1, s, 1'b0);
        ack = ~s;
    endtask

    task automatic rd_byte(output logic [7:0] d, input logic give_ack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s, 1'b0);
            d[i] = s;
        end
        clk_bit(~give_ack, s, 1'b0);
    endtask

    function automatic logic [7:0] ctl_now();
        return {cap_mode, thr_sel, dac_code};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic s;
        logic [7:0] rd;
        wait_q(10);
        rst_n = 1'b1;
        wait_q(10);
        // R8 reset state
        chk("R8 port", port_release, 8'h00);
        chk("R8 dac", dac_code, 6'd1);
        chk("R8 thr", thr_sel, 1'b0);
        chk("R8 cap", cap_mode, 1'b0);
        chk("R8 sda", sda_drive_low, 1'b0);

        // R1 R2 R3 R4 vector walk
        for (int v = 0; v < 6; v++) begin
            bit hit;
            hit = (VECS[v].adr == MY_ADR);
            bus_start();
            wr_byte({VECS[v].adr, 1'b0}, ack, -1);
            chk("R1 addr ack", ack, hit);
            if (ack && VECS[v].nb >= 2'd1) begin
                wr_byte(VECS[v].d0, ack, -1);
                chk("R2 data0 ack", ack, 1'b1);
                m_port = VECS[v].d0;
            end
            if (ack && VECS[v].nb >= 2'd2) begin
                wr_byte(VECS[v].d1, ack, -1);
                chk("R3 data1 ack", ack, 1'b1);
                m_ctl = VECS[v].d1;
            end
            bus_stop();
            chk("R2 R4 port", port_release, m_port);
            chk("R3 R4 ctl", ctl_now(), m_ctl);
        end

        // R5 third byte refused
        bus_start();
        wr_byte({MY_ADR, 1'b0}, ack, -1);
        wr_byte(8'h11, ack, -1);
        wr_byte(8'h45, ack, -1);
        wr_byte(8'hEE, ack, -1);
        chk("R5 third nack", ack, 1'b0);
        bus_stop();
        chk("R5 port", port_release, 8'h11);
        chk("R5 ctl", ctl_now(), 8'h45);

        // R6 R7 read with reload and NACK
        cmp_in = 8'hC6;
        bus_start();
        wr_byte({MY_ADR, 1'b1}, ack, -1);
        chk("R1 read ack", ack, 1'b1);
        chk("R6 snap pulses", snap_cnt, 1);
        cmp_in = 8'h5A;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s, 1'b0);
            rd[i] = s;
        end
        chk("R6 first byte", rd, 8'hC6);
        cmp_in = 8'h39;
        clk_bit(1'b0, s, 1'b0);
        chk("R7 mack pulses", mack_cnt, 1);
        rd_byte(rd, 1'b0);
        chk("R7 second byte", rd, 8'h39);
        rd_byte(rd, 1'b0);
        chk("R7 released after nack", rd, 8'hFF);
        bus_stop();
        chk("R7 regs untouched", port_release, 8'h11);

        // R9 aborts in address and data
        bus_start();
        for (int i = 0; i < 4; i++) clk_bit(1'b0, s, 1'b0);
        bus_start();
        wr_byte({MY_ADR, 1'b0}, ack, -1);
        chk("R9 addr after abort", ack, 1'b1);
        for (int i = 0; i < 3; i++) clk_bit(1'b1, s, 1'b0);
        bus_start();
        chk("R9 port held", port_release, 8'h11);
        wr_byte({MY_ADR, 1'b0}, ack, -1);
        wr_byte(8'h5A, ack, -1);
        chk("R10 data ack low", ack, 1'b1);
        bus_stop();
        chk("R9 port new", port_release, 8'h5A);

        // R11 short SCL glitch ignored
        bus_start();
        wr_byte({MY_ADR, 1'b0}, ack, 4);
        chk("R11 ack with glitch", ack, 1'b1);
        wr_byte(8'h96, ack, 2);
        bus_stop();
        chk("R11 port", port_release, 8'h96);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule